// File: doc/BRIEF.md
# Page Translation Buffer with Write Protection

This block caches recent virtual-to-physical page mappings for 4 KB pages. A lookup presents a 32-bit virtual address and a read/write flag. All stored tags are compared in parallel. On a hit, the block returns a 30-bit physical address in the same cycle. If no valid entry matches, it flags a miss. If a write targets a page whose entry lacks write permission, it flags a protection fault instead of completing the access.

Each entry keeps a reference bit and a dirty bit, and the hardware maintains both. A completed access sets the entry's reference bit. A completed write also sets its dirty bit. A lookup reports the entry's stored bits as they stood before that access, so an external walker or handler can read them.

New mappings come in through a fill port. A fill goes to the lowest-numbered empty entry. When no entry is empty, it goes to the entry named by a rotating pointer. A flush input empties the whole buffer in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: On a completed access, `lk_paddr_o` equals the matching entry's 18-bit frame number concatenated above virtual address bits 11..0. Bits 31..12 of the virtual address form the 20-bit page tag. `lk_paddr_o` is zero when there is no completed access.
- R2: A lookup whose page tag matches no valid entry raises `lk_miss_o` with `lk_hit_o` and `lk_prot_o` low. At most one of the three flags is high in any cycle.
- R3: A write lookup that matches an entry whose write permission is 0 raises `lk_prot_o`, leaves `lk_hit_o` and `lk_miss_o` low, and changes neither that entry's reference bit nor its dirty bit.
- R4: A newly filled entry has reference and dirty bits of 0. A completed access sets the entry's reference bit from the next cycle on. `lk_ref_o` and `lk_dirty_o` show the matching entry's stored bits before the current access, and are 0 on a miss.
- R5: A completed write sets the matching entry's dirty bit from the next cycle on.
- R6: A fill that arrives while any entry is empty installs into the lowest-numbered empty entry and leaves the rotating pointer unchanged.
- R7: A fill that arrives while all entries are valid replaces the entry at the rotating pointer and advances the pointer by one, wrapping after the last entry. The pointer is 0 after reset.
- R8: A flush makes every entry invalid from the next cycle on. A fill in the same cycle as a flush is discarded.
- R9: After reset every entry is invalid, so every lookup misses.
- R10: Results are combinational in the lookup cycle. With `lk_valid_i` low, `lk_hit_o`, `lk_miss_o` and `lk_prot_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_write_i | input | 1 | Lookup is a write |
| lk_vaddr_i | input | 32 | Virtual address |
| lk_hit_o | output | 1 | Access completed |
| lk_miss_o | output | 1 | No valid mapping |
| lk_prot_o | output | 1 | Write to a page without write permission |
| lk_paddr_o | output | 30 | Physical address |
| lk_ref_o | output | 1 | Stored reference bit of the matching entry |
| lk_dirty_o | output | 1 | Stored dirty bit of the matching entry |
| fill_valid_i | input | 1 | Install a mapping |
| fill_vpn_i | input | 20 | Page tag to install |
| fill_ppn_i | input | 18 | Frame number to install |
| fill_wr_ok_i | input | 1 | Write permission of the new entry |

## Verification
The checks assume that fills never install a page tag already present among the valid entries, so that at most one entry matches any lookup. The stimulus keeps to this: every installed tag is unique until a flush or an eviction removes it. The reference and dirty update checks also assume that no fill or flush lands in the cycle after the access. The stimulus separates these operations by at least one idle cycle.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush_i,
  input  logic                   lk_valid_i,
  input  logic                   lk_write_i,
  input  logic [VA_W-1:0]        lk_vaddr_i,
  output logic                   lk_hit_o,
  output logic                   lk_miss_o,
  output logic                   lk_prot_o,
  output logic [PA_W-1:0]        lk_paddr_o,
  output logic                   lk_ref_o,
  output logic                   lk_dirty_o,
  input  logic                   fill_valid_i,
  input  logic [VA_W-OFF_W-1:0]  fill_vpn_i,
  input  logic [PA_W-OFF_W-1:0]  fill_ppn_i,
  input  logic                   fill_wr_ok_i
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, ref_q, dirty_q, wok_q;
  logic [IDX_W-1:0]   rot_q;

  logic [ENTRIES-1:0] match_v;
  logic [IDX_W-1:0]   hit_idx, free_idx, victim;
  logic               any_match, denied, all_full;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_v[g] = vld_q[g] && (tag_q[g] == lk_vaddr_i[VA_W-1:OFF_W]);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_v[i]) hit_idx  = IDX_W'(i);
      if (!vld_q[i])  free_idx = IDX_W'(i);
    end
  end

  assign any_match  = |match_v;
  assign all_full   = &vld_q;
  assign victim     = all_full ? rot_q : free_idx;
  assign denied     = lk_write_i && !wok_q[hit_idx];
  assign lk_miss_o  = lk_valid_i && !any_match;
  assign lk_prot_o  = lk_valid_i && any_match && denied;
  assign lk_hit_o   = lk_valid_i && any_match && !denied;
  assign lk_paddr_o = lk_hit_o ? {ppn_q[hit_idx], lk_vaddr_i[OFF_W-1:0]} : '0;
  assign lk_ref_o   = lk_valid_i && any_match && ref_q[hit_idx];
  assign lk_dirty_o = lk_valid_i && any_match && dirty_q[hit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      wok_q   <= '0;
      rot_q   <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else begin
      if (lk_hit_o) begin
        ref_q[hit_idx] <= 1'b1;
        if (lk_write_i) dirty_q[hit_idx] <= 1'b1;
      end
      if (fill_valid_i) begin
        vld_q[victim]   <= 1'b1;
        ref_q[victim]   <= 1'b0;
        dirty_q[victim] <= 1'b0;
        wok_q[victim]   <= fill_wr_ok_i;
        if (all_full) rot_q <= rot_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid_i && !flush_i) begin
      tag_q[victim] <= fill_vpn_i;
      ppn_q[victim] <= fill_ppn_i;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 30,
  parameter int OFF_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic               lk_valid_i,
  input logic               lk_write_i,
  input logic [VA_W-1:0]    lk_vaddr_i,
  input logic               lk_hit_o,
  input logic               lk_miss_o,
  input logic               lk_prot_o,
  input logic [PA_W-1:0]    lk_paddr_o,
  input logic               fill_valid_i,
  input logic [ENTRIES-1:0] match_v,
  input logic [ENTRIES-1:0] vld_q,
  input logic [ENTRIES-1:0] ref_q,
  input logic [ENTRIES-1:0] dirty_q
);
  assert_unique_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_v));
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit_o, lk_miss_o, lk_prot_o}));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_prot_o));
  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit_o |-> lk_paddr_o[OFF_W-1:0] == lk_vaddr_i[OFF_W-1:0]);
  assert_prot_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_prot_o |-> lk_write_i);
  assert_ref_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit_o && !fill_valid_i && !flush_i) |=> ((ref_q & $past(match_v)) == $past(match_v)));
  assert_dirty_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit_o && lk_write_i && !fill_valid_i && !flush_i) |=>
      ((dirty_q & $past(match_v)) == $past(match_v)));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (vld_q == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .lk_valid_i(lk_valid_i),
  .lk_write_i(lk_write_i), .lk_vaddr_i(lk_vaddr_i), .lk_hit_o(lk_hit_o),
  .lk_miss_o(lk_miss_o), .lk_prot_o(lk_prot_o), .lk_paddr_o(lk_paddr_o),
  .fill_valid_i(fill_valid_i), .match_v(match_v), .vld_q(vld_q),
  .ref_q(ref_q), .dirty_q(dirty_q)
);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic        lk_write_i = 1'b0;
  logic [31:0] lk_vaddr_i = '0;
  logic        lk_hit_o, lk_miss_o, lk_prot_o, lk_ref_o, lk_dirty_o;
  logic [29:0] lk_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [17:0] fill_ppn_i = '0;
  logic        fill_wr_ok_i = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tlb_xlate dut_i (.*);

  function automatic logic [19:0] vpn_a(int i); return 20'hC0000 + 20'(i) * 20'd4099; endfunction
  function automatic logic [17:0] ppn_a(int i); return 18'h2A000 + 18'(i) * 18'd97; endfunction
  function automatic logic [19:0] vpn_r(int i); return 20'h50000 + 20'(i) * 20'd13; endfunction
  function automatic logic [17:0] ppn_r(int i); return 18'h01000 + 18'(i) * 18'd311; endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_clear();
    @(posedge clk); #1;
    lk_valid_i = 0; lk_write_i = 0; fill_valid_i = 0; flush_i = 0;
  endtask

  task automatic fill(logic [19:0] vpn, logic [17:0] ppn, logic wok, logic fl);
    @(negedge clk);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_wr_ok_i = wok; flush_i = fl;
    idle_clear();
  endtask

  // expected flags {hit,miss,prot}; paddr checked on hit; ref/dirty checked when matched
  task automatic look(string req, logic wr, logic [19:0] vpn, logic [11:0] off,
                      logic [2:0] flags, logic [17:0] ppn, logic eref, logic edirty);
    @(negedge clk);
    lk_valid_i = 1; lk_write_i = wr; lk_vaddr_i = {vpn, off};
    #1;
    chk(req, {61'd0, lk_hit_o, lk_miss_o, lk_prot_o}, {61'd0, flags});
    if (flags[2]) chk(req, {34'd0, lk_paddr_o}, {34'd0, ppn, off});
    else chk(req, {34'd0, lk_paddr_o}, 64'd0);
    chk(req, {62'd0, lk_ref_o, lk_dirty_o}, {62'd0, eref, edirty});
    idle_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10: idle outputs quiet
    @(negedge clk);
    chk("R10", {61'd0, lk_hit_o, lk_miss_o, lk_prot_o}, 64'd0);
    // R9: empty after reset
    look("R9", 0, vpn_a(0), 12'h123, 3'b010, '0, 0, 0);
    // R6: fill empty buffer
    for (int i = 0; i < 16; i++) fill(vpn_a(i), ppn_a(i), i[0], 0);
    for (int i = 0; i < 16; i++) begin
      look("R1", 0, vpn_a(i), 12'((i * 251) & 32'hfff), 3'b100, ppn_a(i), 0, 0);
      look("R4", 0, vpn_a(i), 12'hfff, 3'b100, ppn_a(i), 1, 0);
    end
    look("R2", 0, 20'h00001, 12'h0, 3'b010, '0, 0, 0);
    look("R2", 1, 20'hFFFFF, 12'h7, 3'b010, '0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      if (i[0]) begin
        look("R5", 1, vpn_a(i), 12'h040, 3'b100, ppn_a(i), 1, 0);
        look("R5", 0, vpn_a(i), 12'h040, 3'b100, ppn_a(i), 1, 1);
      end else begin
        look("R3", 1, vpn_a(i), 12'h040, 3'b001, '0, 1, 0);
        look("R3", 0, vpn_a(i), 12'h040, 3'b100, ppn_a(i), 1, 0);
      end
    end
    // R7: full, pointer 0 then 1
    fill(20'h11111, 18'h00AAA, 1, 0);
    look("R7", 0, vpn_a(0), 12'h0, 3'b010, '0, 0, 0);
    look("R7", 0, 20'h11111, 12'h5, 3'b100, 18'h00AAA, 0, 0);
    look("R7", 0, vpn_a(1), 12'h5, 3'b100, ppn_a(1), 1, 1);
    fill(20'h22222, 18'h00BBB, 1, 0);
    look("R7", 0, vpn_a(1), 12'h0, 3'b010, '0, 0, 0);
    look("R7", 0, vpn_a(2), 12'h0, 3'b100, ppn_a(2), 1, 0);
    look("R7", 0, 20'h22222, 12'h9, 3'b100, 18'h00BBB, 0, 0);
    // R8: flush with a simultaneous fill
    fill(20'h33333, 18'h00CCC, 1, 1);
    look("R8", 0, vpn_a(2), 12'h0, 3'b010, '0, 0, 0);
    look("R8", 0, 20'h11111, 12'h0, 3'b010, '0, 0, 0);
    look("R8", 0, 20'h33333, 12'h0, 3'b010, '0, 0, 0);
    // R6: refill goes to empty slots 0..15; pointer stays at 2
    for (int k = 0; k < 16; k++) fill(vpn_r(k), ppn_r(k), k != 0, 0);
    look("R3", 1, vpn_r(0), 12'h3, 3'b001, '0, 0, 0);
    look("R3", 0, vpn_r(0), 12'h3, 3'b100, ppn_r(0), 0, 0);
    fill(20'h77777, 18'h00DDD, 1, 0);
    look("R6", 0, vpn_r(2), 12'h0, 3'b010, '0, 0, 0);
    look("R6", 0, vpn_r(0), 12'h0, 3'b100, ppn_r(0), 1, 0);
    look("R7", 0, vpn_r(1), 12'h0, 3'b100, ppn_r(1), 0, 0);
    look("R7", 1, 20'h77777, 12'hABC, 3'b100, 18'h00DDD, 0, 0);
    look("R5", 0, 20'h77777, 12'hABC, 3'b100, 18'h00DDD, 1, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule